// File: doc/BRIEF.md
# Memory-Card Transfer Sequencer

This block orders the command phase and the data phase of a memory-card host controller. A processor programs two byte-wide control registers over a simple write/read bus. Three action bits fire only when they are written to 1 and then written back to 0: send a command, expect a response, and start a data transfer. Two abort bits in the second register use the same set-then-clear pattern. They reset the command-line sequencer or the data-line sequencer.

The command sequencer moves through `C_IDLE -> C_LAUNCH -> C_SEND`. When the line engine reports `cmd_done`, it enters `C_RESP` if a response was armed, and otherwise returns to `C_IDLE`. From `C_RESP` it returns to `C_IDLE` on `resp_rcvd`.

The data sequencer starts in `D_IDLE`. On a data trigger it goes to `D_WRESP` if a response is expected, and to `D_TICK` if not. `D_WRESP` moves to `D_DELAY` on `resp_rcvd`. `D_DELAY` counts 3 + 2×delay card-clock ticks and then enters `D_LAUNCH`. `D_TICK` enters `D_LAUNCH` on the next tick. `D_LAUNCH` moves to `D_XFER`, which returns to `D_IDLE` on `dat_done`. Direction, block-length code and flow-control enable go straight to the data engine. Clearing the enable bit stops the card clock and freezes both sequencers.

Top module: `mmc_seq_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `card_clk_en`, `cmd_go`, `cmd_busy`, `dat_go`, `dat_busy` and `len_err` are low.
- R2: Register 0 holds the length code in bits 7:4 and the direction in bit 3. Register 1 holds the enable in bit 7, the delay in bits 2:1 and flow control in bit 0. These drive `blk_code`, `dat_dir`, `card_clk_en` and `flow_en`. Bits 4:3 of register 1 always read 0.
- R3: A 1-then-0 write of register 0 bit 0 produces exactly one one-cycle `cmd_go`, in the second cycle after the clearing write. Setting the bit without clearing it produces no pulse.
- R4: After `cmd_done`, the command sequencer stays busy until `resp_rcvd` if register 0 bit 1 was set then cleared beforehand. Otherwise it goes idle at once.
- R5: A data trigger (register 0 bit 2, set then cleared) with no response expected raises `dat_go` in the cycle after the next `card_tick`.
- R6: With a response expected, `dat_go` rises in the cycle after the (3 + 2×delay)-th `card_tick` that follows `resp_rcvd`, and not earlier.
- R7: After `dat_go` the data sequencer stays busy until `dat_done`, then goes idle.
- R8: A length code above 11 is stored as 11 and sets `len_err`. `len_err` stays set until reset.
- R9: Setting then clearing register 1 bit 6 (data) or bit 5 (command) returns only that sequencer to idle and cancels a pending delay. Register contents are unchanged.
- R10: While the enable bit is 0, `card_clk_en` is low, triggers are ignored, and the sequencer states and the delay count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| card_tick | input | 1 | One-cycle card-clock period marker |
| cmd_done | input | 1 | Command shifter finished |
| resp_rcvd | input | 1 | Response received |
| dat_done | input | 1 | Data engine finished |
| card_clk_en | output | 1 | Card clock enable |
| cmd_go | output | 1 | Start command shifting |
| cmd_busy | output | 1 | Command sequencer not idle |
| dat_go | output | 1 | Start data phase |
| dat_busy | output | 1 | Data sequencer not idle |
| dat_dir | output | 1 | 1 = host to card, 0 = card to host |
| blk_code | output | 4 | Block-length code |
| flow_en | output | 1 | Flow control enable |
| len_err | output | 1 | Sticky illegal-length flag |

## Verification
The bench builds the block with its default limit of 11 on the length code. That places the clamp boundary between the legal code 11 and the illegal codes 12 to 15, and the bench writes on both sides of it. The two-bit delay field is exercised at all four settings, which covers every response-to-data spacing from 3 to 9 ticks. Extra clock cycles without ticks are placed inside the delay window so that only ticks are counted.

// File: rtl/mmc_seq_pkg.sv
package mmc_seq_pkg;
    localparam int REG_W  = 8;
    localparam int BLEN_W = 4;
    localparam int DLY_W  = 2;
    localparam logic [REG_W-1:0] CTL_KEEP = 8'hE7;

    typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_SEND, C_RESP} cmd_st_t;
    typedef enum logic [2:0] {D_IDLE, D_WRESP, D_TICK, D_DELAY, D_LAUNCH, D_XFER} dat_st_t;

    typedef struct packed {
        logic cmd;
        logic resp;
        logic dat;
        logic cmd_abort;
        logic dat_abort;
    } trig_t;
endpackage

// File: rtl/mmc_seq_regs.sv
module mmc_seq_regs
    import mmc_seq_pkg::*;
#(
    parameter int BLEN_MAX = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output trig_t             trig,
    output logic [BLEN_W-1:0] blk_code,
    output logic              dir,
    output logic              en,
    output logic [DLY_W-1:0]  dly,
    output logic              flow,
    output logic              len_err
);
    logic [REG_W-1:0]  xfer_q, ctl_q;
    logic              over;
    logic [BLEN_W-1:0] blen_c;

    always_comb begin
        over   = (int'(wdata[7:4]) > BLEN_MAX);
        blen_c = over ? BLEN_W'(BLEN_MAX) : wdata[7:4];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_q  <= '0;
            ctl_q   <= '0;
            trig    <= '0;
            len_err <= 1'b0;
        end else begin
            trig <= '0;
            if (wr && !addr) begin
                xfer_q    <= {blen_c, wdata[3:0]};
                trig.cmd  <= xfer_q[0] & ~wdata[0];
                trig.resp <= xfer_q[1] & ~wdata[1];
                trig.dat  <= xfer_q[2] & ~wdata[2];
                len_err   <= len_err | over;
            end else if (wr && addr) begin
                ctl_q          <= wdata & CTL_KEEP;
                trig.dat_abort <= ctl_q[6] & ~wdata[6];
                trig.cmd_abort <= ctl_q[5] & ~wdata[5];
            end
        end
    end

    assign rdata    = addr ? ctl_q : xfer_q;
    assign blk_code = xfer_q[7:4];
    assign dir      = xfer_q[3];
    assign en       = ctl_q[7];
    assign dly      = ctl_q[2:1];
    assign flow     = ctl_q[0];
endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
    import mmc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmd_p,
    input  logic resp_p,
    input  logic abort_p,
    input  logic cmd_done,
    input  logic resp_rcvd,
    output logic cmd_go,
    output logic cmd_busy,
    output logic resp_pend
);
    cmd_st_t st, nxt;
    logic    arm, arm_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= C_IDLE;
            arm <= 1'b0;
        end else begin
            st  <= nxt;
            arm <= arm_n;
        end
    end

    always_comb begin
        nxt   = st;
        arm_n = arm;
        if (abort_p) begin
            nxt   = C_IDLE;
            arm_n = 1'b0;
        end else if (en) begin
            if (resp_p) arm_n = 1'b1;
            unique case (st)
                C_IDLE:   if (cmd_p) nxt = C_LAUNCH;
                C_LAUNCH: nxt = C_SEND;
                C_SEND:   if (cmd_done) nxt = arm_n ? C_RESP : C_IDLE;
                C_RESP:   if (resp_rcvd) begin
                              nxt   = C_IDLE;
                              arm_n = 1'b0;
                          end
                default:  nxt = C_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_go    = en && (st == C_LAUNCH);
        cmd_busy  = (st != C_IDLE);
        resp_pend = arm | resp_p;
    end
endmodule

// File: rtl/mmc_dat_seq.sv
module mmc_dat_seq
    import mmc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dat_p,
    input  logic             abort_p,
    input  logic             resp_pend,
    input  logic             resp_rcvd,
    input  logic             card_tick,
    input  logic             dat_done,
    input  logic [DLY_W-1:0] dly,
    output logic             dat_go,
    output logic             dat_busy
);
    localparam int CNT_W = $clog2(2 ** (DLY_W + 1) + 2);

    dat_st_t          st, nxt;
    logic [CNT_W-1:0] cnt, cnt_n, target;

    assign target = CNT_W'(3) + CNT_W'({dly, 1'b0});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= D_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        nxt   = st;
        cnt_n = cnt;
        if (abort_p) begin
            nxt   = D_IDLE;
            cnt_n = '0;
        end else if (en) begin
            unique case (st)
                D_IDLE:   if (dat_p) nxt = resp_pend ? D_WRESP : D_TICK;
                D_WRESP:  if (resp_rcvd) begin
                              nxt   = D_DELAY;
                              cnt_n = '0;
                          end
                D_TICK:   if (card_tick) nxt = D_LAUNCH;
                D_DELAY:  if (card_tick) begin
                              if (cnt == target - 1'b1) nxt = D_LAUNCH;
                              else cnt_n = cnt + 1'b1;
                          end
                D_LAUNCH: nxt = D_XFER;
                D_XFER:   if (dat_done) nxt = D_IDLE;
                default:  nxt = D_IDLE;
            endcase
        end
    end

    always_comb begin
        dat_go   = en && (st == D_LAUNCH);
        dat_busy = (st != D_IDLE);
    end
endmodule

// File: rtl/mmc_seq_ctrl.sv
module mmc_seq_ctrl
    import mmc_seq_pkg::*;
#(
    parameter int BLEN_MAX = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        card_tick,
    input  logic        cmd_done,
    input  logic        resp_rcvd,
    input  logic        dat_done,
    output logic        card_clk_en,
    output logic        cmd_go,
    output logic        cmd_busy,
    output logic        dat_go,
    output logic        dat_busy,
    output logic        dat_dir,
    output logic [3:0]  blk_code,
    output logic        flow_en,
    output logic        len_err
);
    trig_t            trig;
    logic             en;
    logic [DLY_W-1:0] dly;
    logic             resp_pend;
    logic             cmd_abort_p, dat_abort_p;

    mmc_seq_regs #(.BLEN_MAX(BLEN_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .trig(trig),
        .blk_code(blk_code), .dir(dat_dir), .en(en), .dly(dly),
        .flow(flow_en), .len_err(len_err)
    );

    assign cmd_abort_p = trig.cmd_abort;
    assign dat_abort_p = trig.dat_abort;
    assign card_clk_en = en;

    mmc_cmd_seq u_cmd (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd_p(trig.cmd),
        .resp_p(trig.resp), .abort_p(cmd_abort_p), .cmd_done(cmd_done),
        .resp_rcvd(resp_rcvd), .cmd_go(cmd_go), .cmd_busy(cmd_busy),
        .resp_pend(resp_pend)
    );

    mmc_dat_seq u_dat (
        .clk(clk), .rst_n(rst_n), .en(en), .dat_p(trig.dat),
        .abort_p(dat_abort_p), .resp_pend(resp_pend), .resp_rcvd(resp_rcvd),
        .card_tick(card_tick), .dat_done(dat_done), .dly(dly),
        .dat_go(dat_go), .dat_busy(dat_busy)
    );
endmodule

// File: rtl/mmc_seq_ctrl_chk.sv
module mmc_seq_ctrl_chk #(
    parameter int BLEN_MAX = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic [7:0] bus_rdata,
    input logic       card_clk_en,
    input logic       cmd_go,
    input logic       cmd_busy,
    input logic       dat_go,
    input logic       dat_busy,
    input logic [3:0] blk_code,
    input logic       len_err,
    input logic       cmd_abort_p,
    input logic       dat_abort_p
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr |-> (bus_rdata[4:3] == 2'b00));
    // R3
    cmd_go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);
    // R7
    dat_go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_go && !dat_abort_p) |=> dat_busy);
    // R8
    blk_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blk_code) <= BLEN_MAX);
    // R8
    len_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);
    // R9
    dat_abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_abort_p |=> (!dat_busy && !dat_go));
    // R10
    freeze_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk_en && !cmd_abort_p) |=> $stable(cmd_busy));
    // R10
    freeze_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk_en && !dat_abort_p) |=> ($stable(dat_busy) && !dat_go));
endmodule

bind mmc_seq_ctrl mmc_seq_ctrl_chk #(.BLEN_MAX(BLEN_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .card_clk_en(card_clk_en), .cmd_go(cmd_go), .cmd_busy(cmd_busy),
    .dat_go(dat_go), .dat_busy(dat_busy), .blk_code(blk_code),
    .len_err(len_err), .cmd_abort_p(cmd_abort_p), .dat_abort_p(dat_abort_p)
);

// File: tb/tb_mmc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_mmc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       card_tick = 1'b0, cmd_done = 1'b0, resp_rcvd = 1'b0, dat_done = 1'b0;
    logic       card_clk_en, cmd_go, cmd_busy, dat_go, dat_busy, dat_dir, flow_en, len_err;
    logic [3:0] blk_code;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mmc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_tick(card_tick),
        .cmd_done(cmd_done), .resp_rcvd(resp_rcvd), .dat_done(dat_done),
        .card_clk_en(card_clk_en), .cmd_go(cmd_go), .cmd_busy(cmd_busy),
        .dat_go(dat_go), .dat_busy(dat_busy), .dat_dir(dat_dir),
        .blk_code(blk_code), .flow_en(flow_en), .len_err(len_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 tick, 1 cmd_done, 2 resp_rcvd, 3 dat_done
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: card_tick = 1'b1;
            1: cmd_done  = 1'b1;
            2: resp_rcvd = 1'b1;
            default: dat_done = 1'b1;
        endcase
        @(negedge clk);
        card_tick = 1'b0; cmd_done = 1'b0; resp_rcvd = 1'b0; dat_done = 1'b0;
    endtask

    task automatic t_reset();
        rd(1'b0, 8'h00, "R1 reg0");
        rd(1'b1, 8'h00, "R1 reg1");
        check("R1 outputs", {card_clk_en, cmd_go, cmd_busy, dat_go, dat_busy, len_err}, 0);
    endtask

    task automatic t_fields();
        wr(1'b0, 8'h58);
        check("R2 blk_code", blk_code, 4'h5);
        check("R2 dat_dir", dat_dir, 1'b1);
        rd(1'b0, 8'h58, "R2 reg0 readback");
        wr(1'b1, 8'h9F);
        rd(1'b1, 8'h87, "R2 reserved bits");
        check("R2 flow_en", flow_en, 1'b1);
        check("R2 card_clk_en", card_clk_en, 1'b1);
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h00);
        check("R2 dat_dir clear", dat_dir, 1'b0);
    endtask

    task automatic t_cmd();
        wr(1'b0, 8'h01);
        idle(2);
        check("R3 set alone no pulse", {cmd_go, cmd_busy}, 0);
        wr(1'b0, 8'h00);
        @(negedge clk);
        check("R3 cmd_go", cmd_go, 1'b1);
        @(negedge clk);
        check("R3 cmd_go one cycle", cmd_go, 1'b0);
        check("R4 busy while sending", cmd_busy, 1'b1);
        pulse(1);
        check("R4 idle without response", cmd_busy, 1'b0);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h00);
        idle(2);
        pulse(1);
        idle(3);
        check("R4 waits for response", cmd_busy, 1'b1);
        pulse(2);
        check("R4 idle after response", cmd_busy, 1'b0);
    endtask

    task automatic t_dat_noresp();
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        idle(3);
        check("R5 no go before tick", dat_go, 1'b0);
        check("R5 busy waiting tick", dat_busy, 1'b1);
        pulse(0);
        check("R5 go after tick", dat_go, 1'b1);
        @(negedge clk);
        check("R7 busy during transfer", {dat_go, dat_busy}, 2'b01);
        pulse(3);
        check("R7 idle after done", dat_busy, 1'b0);
    endtask

    task automatic t_dat_delay(input int d);
        int target;
        target = 3 + 2 * d;
        wr(1'b1, 8'h80 | 8'(d << 1));
        wr(1'b0, 8'h07);
        wr(1'b0, 8'h00);
        idle(2);
        pulse(1);
        idle(2);
        check("R6 no go before response", dat_go, 1'b0);
        pulse(2);
        for (int k = 1; k <= target; k++) begin
            idle(1);
            pulse(0);
            if (k < target) check("R6 early go", dat_go, 1'b0);
            else            check("R6 go at delay end", dat_go, 1'b1);
        end
        pulse(3);
        check("R7 idle after delayed transfer", dat_busy, 1'b0);
    endtask

    task automatic t_clamp();
        check("R8 no error yet", len_err, 1'b0);
        wr(1'b0, 8'hB0);
        check("R8 legal max", {blk_code, len_err}, {4'hB, 1'b0});
        wr(1'b0, 8'hF0);
        check("R8 clamped", blk_code, 4'hB);
        rd(1'b0, 8'hB0, "R8 clamped readback");
        check("R8 error set", len_err, 1'b1);
        wr(1'b0, 8'h30);
        check("R8 error sticky", {blk_code, len_err}, {4'h3, 1'b1});
    endtask

    task automatic t_abort();
        logic seen;
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h37);
        wr(1'b0, 8'h30);
        idle(2);
        pulse(1);
        pulse(2);
        pulse(0);
        wr(1'b1, 8'hC0);
        wr(1'b1, 8'h80);
        @(negedge clk);
        check("R9 data sequencer idle", dat_busy, 1'b0);
        rd(1'b1, 8'h80, "R9 reg1 unchanged");
        rd(1'b0, 8'h30, "R9 reg0 unchanged");
        seen = 1'b0;
        for (int k = 0; k < 5; k++) begin
            pulse(0);
            seen = seen | dat_go;
        end
        check("R9 delay cancelled", seen, 1'b0);
        wr(1'b0, 8'h31);
        wr(1'b0, 8'h30);
        idle(2);
        check("R9 command busy", cmd_busy, 1'b1);
        wr(1'b1, 8'hA0);
        wr(1'b1, 8'h80);
        @(negedge clk);
        check("R9 command sequencer idle", {cmd_busy, dat_busy}, 2'b00);
    endtask

    task automatic t_freeze();
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        idle(2);
        wr(1'b1, 8'h00);
        check("R10 clock stopped", card_clk_en, 1'b0);
        pulse(0);
        pulse(0);
        check("R10 data frozen", {dat_go, dat_busy}, 2'b01);
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h00);
        idle(2);
        check("R10 trigger ignored", {cmd_go, cmd_busy}, 0);
        wr(1'b1, 8'h80);
        idle(1);
        check("R10 resumes waiting", {dat_go, dat_busy}, 2'b01);
        pulse(0);
        check("R10 go after re-enable", dat_go, 1'b1);
        pulse(3);
        check("R10 idle at end", {cmd_busy, dat_busy}, 2'b00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fields();
        t_cmd();
        t_dat_noresp();
        for (int d = 0; d < 4; d++) t_dat_delay(d);
        t_clamp();
        t_abort();
        t_freeze();
        finish_run();
    end
endmodule